// File: doc/BRIEF.md
# EDC Diagnostic Capture and Readback

This block is the diagnostic half of a 32-bit flow-through error detection and correction unit. On every rising edge of the sync clock it samples the active-low error flag coming out of the correction path. The first error seen after a clear freezes a snapshot: the raw memory word, the 8-bit syndrome, and a 2-bit error type (single or multiple bit). A 4-bit counter tallies every flagged edge and stops at 15. The same block holds the 8-bit checkbit input latch. In one mode that latch can be loaded from the low byte of the system data input, so that known-bad checkbits can be injected to exercise the corrector on the board.

A 3-bit mode input selects what the 32-bit system data output carries:
- the corrected word (normal and injection modes);
- the raw memory word (generate-detect);
- the captured error word;
- a packed diagnostic word.

Just after a clear, the captured error word reads as all zeros. It can therefore feed zeros to memory during hardware initialization.

The capture logic is a small state machine with three states:
- `CAP_ARMED`: no error has been recorded since the clear. A flagged edge captures the snapshot, counts one and moves to `CAP_COUNTING`.
- `CAP_COUNTING`: a snapshot is held. A flagged edge increments the count. When the count passes from 14 to 15 the machine moves to `CAP_FULL`.
- `CAP_FULL`: the count stays saturated at 15.

An active-low clear returns the machine to `CAP_ARMED` from any state.

Top module: `edc_diag_unit`

## Requirements
- R1: Modes 3'b011, 3'b111 (normal) and 3'b100 (injection) drive `corr_data` onto `sys_out`.
- R2: Modes 3'b010 and 3'b110 (generate-detect) drive the uncorrected `mem_data` onto `sys_out`.
- R3: Mode 3'b000 drives the error-data register onto `sys_out`.
- R4: The error-data register loads `mem_data` on a rising `clk` edge only when `err_n` is low and the count before the edge is zero. Later errors leave it unchanged.
- R5: The syndrome register captures `syndrome` under exactly the same first-error condition as R4.
- R6: Each rising edge with `err_n` low adds one to the 4-bit error count, unless the count is already 15, where it stays. Edges with `err_n` high leave the count unchanged.
- R7: The error-type register records 2'b01 for a single-bit error (`multi_err`=0) or 2'b10 for a multiple-bit error (`multi_err`=1), only for the first error after a clear. It reads 2'b00 when no error has been recorded.
- R8: Driving `clr_n` low clears the error-data, syndrome, count and error-type registers at once, with no clock edge needed. After that, mode 3'b000 reads all zeros.
- R9: Modes 3'b001 and 3'b101 output the diagnostic word, laid out as follows:
  - bits 31:30 error type;
  - bits 29:28 zero;
  - bits 27:24 count;
  - bits 23:16 syndrome register;
  - bits 15:8 the live `partial_cb` input;
  - bits 7:0 checkbit latch.
- R10: On a rising edge with `mem_le` high, the checkbit latch loads `mem_cb`, or `sys_in[7:0]` when the mode is 3'b100. With `mem_le` low it holds its value.
- R11: Clear takes priority: an edge that arrives while `clr_n` is low captures nothing and counts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock; every register updates on its rising edge |
| clr_n | input | 1 | Asynchronous active-low clear of the error records |
| mode | input | 3 | Output and injection mode select |
| err_n | input | 1 | Active-low error flag from the correction path |
| multi_err | input | 1 | 1 when the flagged error is a multiple-bit error |
| mem_data | input | 32 | Uncorrected memory word from the data input latch |
| corr_data | input | 32 | Corrected word from the correction network |
| syndrome | input | 8 | Syndrome of the current word |
| mem_cb | input | 8 | Checkbits read from memory |
| mem_le | input | 1 | Memory latch enable for the checkbit latch |
| partial_cb | input | 8 | Partial checkbit bus, shown unlatched in the diagnostic word |
| sys_in | input | 32 | System data input latch; low byte is the injection value |
| sys_out | output | 32 | System data output word |

## Verification
The bench builds the block with its default widths: a 32-bit word, 8-bit checkbits and syndrome, and a 4-bit counter. With these widths the diagnostic word packs exactly into 32 bits. A short burst of about twenty flagged edges carries the counter through the 14-to-15 step into saturation, so all three capture states and every transition between them are reached within a few dozen cycles. The default widths also let the bench check each packed field bit for bit against its own model. That covers the case where a clear edge and an error edge fall together.

// File: rtl/edc_diag_pkg.sv
package edc_diag_pkg;

    typedef enum logic [1:0] {
        CAP_ARMED    = 2'd0,
        CAP_COUNTING = 2'd1,
        CAP_FULL     = 2'd2
    } cap_state_t;

    typedef enum logic [1:0] {
        SEL_CORR    = 2'd0,
        SEL_RAW     = 2'd1,
        SEL_ERRDATA = 2'd2,
        SEL_DIAG    = 2'd3
    } out_sel_t;

    localparam int          ET_W      = 2;
    localparam logic [1:0]  ET_NONE   = 2'b00;
    localparam logic [1:0]  ET_SINGLE = 2'b01;
    localparam logic [1:0]  ET_MULTI  = 2'b10;
    localparam logic [2:0]  MODE_INJECT = 3'b100;

    function automatic out_sel_t decode_mode(input logic [2:0] m);
        out_sel_t s;
        unique case (m[1:0])
            2'b11:   s = SEL_CORR;
            2'b10:   s = SEL_RAW;
            2'b01:   s = SEL_DIAG;
            default: s = m[2] ? SEL_CORR : SEL_ERRDATA;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/edc_cb_latch.sv
module edc_cb_latch #(
    parameter int CB_W = 8
) (
    input  logic            clk,
    input  logic            le,
    input  logic            inject,
    input  logic [CB_W-1:0] mem_cb,
    input  logic [CB_W-1:0] sys_cb,
    output logic [CB_W-1:0] cb_q
);
    logic [CB_W-1:0] cb_next;

    always_comb begin
        cb_next = inject ? sys_cb : mem_cb;
    end

    always_ff @(posedge clk) begin
        if (le) begin
            cb_q <= cb_next;
        end
    end
endmodule

// File: rtl/edc_err_capture.sv
module edc_err_capture
    import edc_diag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SYN_W  = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              err_n,
    input  logic              multi_err,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [SYN_W-1:0]  syndrome,
    output logic [DATA_W-1:0] err_data,
    output logic [SYN_W-1:0]  syn_q,
    output logic [CNT_W-1:0]  err_cnt,
    output logic [ET_W-1:0]   err_type
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_MAX - 1'b1;

    cap_state_t state_q, state_d;
    logic       capture_en;
    logic       count_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_ARMED: begin
                if (!err_n) state_d = CAP_COUNTING;
            end
            CAP_COUNTING: begin
                if (!err_n && err_cnt == CAP_LAST_CNT()) state_d = CAP_FULL;
            end
            CAP_FULL: begin
                state_d = CAP_FULL;
            end
            default: state_d = CAP_ARMED;
        endcase
    end

    function automatic logic [CNT_W-1:0] CAP_LAST_CNT();
        return CNT_LAST;
    endfunction

    // state register
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) state_q <= CAP_ARMED;
        else        state_q <= state_d;
    end

    // output decode from state
    always_comb begin
        capture_en = 1'b0;
        count_en   = 1'b0;
        unique case (state_q)
            CAP_ARMED: begin
                capture_en = !err_n;
                count_en   = !err_n;
            end
            CAP_COUNTING: begin
                count_en   = !err_n;
            end
            CAP_FULL: begin
                count_en   = 1'b0;
            end
            default: begin
                capture_en = 1'b0;
                count_en   = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            err_data <= '0;
            syn_q    <= '0;
            err_type <= ET_NONE;
        end else if (capture_en) begin
            err_data <= mem_data;
            syn_q    <= syndrome;
            err_type <= multi_err ? ET_MULTI : ET_SINGLE;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n)        err_cnt <= '0;
        else if (count_en) err_cnt <= err_cnt + 1'b1;
    end
endmodule

// File: rtl/edc_out_mux.sv
module edc_out_mux
    import edc_diag_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  out_sel_t          sel,
    input  logic [DATA_W-1:0] corr_word,
    input  logic [DATA_W-1:0] raw_word,
    input  logic [DATA_W-1:0] err_word,
    input  logic [DATA_W-1:0] diag_word,
    output logic [DATA_W-1:0] out_word
);
    always_comb begin
        unique case (sel)
            SEL_CORR:    out_word = corr_word;
            SEL_RAW:     out_word = raw_word;
            SEL_ERRDATA: out_word = err_word;
            SEL_DIAG:    out_word = diag_word;
            default:     out_word = corr_word;
        endcase
    end
endmodule

// File: rtl/edc_diag_unit.sv
module edc_diag_unit
    import edc_diag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CB_W   = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic [2:0]        mode,
    input  logic              err_n,
    input  logic              multi_err,
    input  logic [DATA_W-1:0] mem_data,
    input  logic [DATA_W-1:0] corr_data,
    input  logic [CB_W-1:0]   syndrome,
    input  logic [CB_W-1:0]   mem_cb,
    input  logic              mem_le,
    input  logic [CB_W-1:0]   partial_cb,
    input  logic [DATA_W-1:0] sys_in,
    output logic [DATA_W-1:0] sys_out
);
    localparam int RSVD_W = DATA_W - 3 * CB_W - CNT_W - ET_W;

    out_sel_t          sel;
    logic              inject;
    logic [CB_W-1:0]   cb_q;
    logic [DATA_W-1:0] err_data;
    logic [CB_W-1:0]   syn_q;
    logic [CNT_W-1:0]  err_cnt;
    logic [ET_W-1:0]   err_type;
    logic [DATA_W-1:0] diag_word;

    always_comb begin
        sel       = decode_mode(mode);
        inject    = (mode == MODE_INJECT);
        diag_word = {err_type, {RSVD_W{1'b0}}, err_cnt, syn_q, partial_cb, cb_q};
    end

    edc_cb_latch #(.CB_W(CB_W)) u_cb (
        .clk    (clk),
        .le     (mem_le),
        .inject (inject),
        .mem_cb (mem_cb),
        .sys_cb (sys_in[CB_W-1:0]),
        .cb_q   (cb_q)
    );

    edc_err_capture #(.DATA_W(DATA_W), .SYN_W(CB_W), .CNT_W(CNT_W)) u_cap (
        .clk       (clk),
        .clr_n     (clr_n),
        .err_n     (err_n),
        .multi_err (multi_err),
        .mem_data  (mem_data),
        .syndrome  (syndrome),
        .err_data  (err_data),
        .syn_q     (syn_q),
        .err_cnt   (err_cnt),
        .err_type  (err_type)
    );

    edc_out_mux #(.DATA_W(DATA_W)) u_mux (
        .sel       (sel),
        .corr_word (corr_data),
        .raw_word  (mem_data),
        .err_word  (err_data),
        .diag_word (diag_word),
        .out_word  (sys_out)
    );
endmodule

// File: rtl/edc_diag_checker.sv
module edc_diag_checker #(
    parameter int DATA_W = 32,
    parameter int CB_W   = 8,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              clr_n,
    input logic              err_n,
    input logic [2:0]        mode,
    input logic [DATA_W-1:0] err_data,
    input logic [CB_W-1:0]   syn_q,
    input logic [CNT_W-1:0]  err_cnt,
    input logic [1:0]        err_type,
    input logic [DATA_W-1:0] sys_out
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!clr_n)
        (!err_n && err_cnt != CNT_TOP) |=> (err_cnt == $past(err_cnt) + 1'b1)); // R6
    AST_CNT_SATURATED: assert property (@(posedge clk) disable iff (!clr_n)
        (err_cnt == CNT_TOP) |=> (err_cnt == CNT_TOP)); // R6
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!clr_n)
        err_n |=> $stable(err_cnt)); // R6
    AST_ERRDATA_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (err_cnt != '0) |=> $stable(err_data)); // R4
    AST_SYN_HOLD: assert property (@(posedge clk) disable iff (!clr_n)
        (err_cnt != '0) |=> $stable(syn_q)); // R5
    AST_TYPE_CODE: assert property (@(posedge clk) disable iff (!clr_n)
        $onehot0(err_type)); // R7
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!clr_n)
        (mode[1:0] == 2'b01) |-> (sys_out[29:28] == 2'b00)); // R9

    always @(negedge clk) begin
        if (!clr_n) begin
            AST_CLEAR_STATE: assert (err_cnt == '0 && err_data == '0 && syn_q == '0 && err_type == 2'b00); // R8
        end
    end
endmodule

bind edc_diag_unit edc_diag_checker #(.DATA_W(DATA_W), .CB_W(CB_W), .CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .clr_n    (clr_n),
    .err_n    (err_n),
    .mode     (mode),
    .err_data (err_data),
    .syn_q    (syn_q),
    .err_cnt  (err_cnt),
    .err_type (err_type),
    .sys_out  (sys_out)
);

// File: tb/edc_diag_unit_test.sv
`timescale 1ns/1ps
module edc_diag_unit_test;
    logic        clk = 1'b0;
    logic        clr_n = 1'b0;
    logic [2:0]  mode = 3'b011;
    logic        err_n = 1'b1;
    logic        multi_err = 1'b0;
    logic [31:0] mem_data = '0;
    logic [31:0] corr_data = '0;
    logic [7:0]  syndrome = '0;
    logic [7:0]  mem_cb = '0;
    logic        mem_le = 1'b0;
    logic [7:0]  partial_cb = '0;
    logic [31:0] sys_in = '0;
    logic [31:0] sys_out;

    int n_run = 0;
    int n_fail = 0;

    // bench model
    logic [31:0] m_ed = '0;
    logic [7:0]  m_syn = '0;
    logic [3:0]  m_cnt = '0;
    logic [1:0]  m_et = '0;
    logic [7:0]  m_cb = '0;

    always #2.5 clk = ~clk;

    edc_diag_unit uut (
        .clk(clk), .clr_n(clr_n), .mode(mode), .err_n(err_n), .multi_err(multi_err),
        .mem_data(mem_data), .corr_data(corr_data), .syndrome(syndrome), .mem_cb(mem_cb),
        .mem_le(mem_le), .partial_cb(partial_cb), .sys_in(sys_in), .sys_out(sys_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic model_clear();
        m_ed = '0; m_syn = '0; m_cnt = '0; m_et = 2'b00;
    endtask

    task automatic err_edge(input logic [31:0] d, input logic [7:0] s, input logic multi);
        mem_data = d; syndrome = s; multi_err = multi; err_n = 1'b0;
        tick();
        if (m_cnt == 4'd0) begin
            m_ed = d; m_syn = s; m_et = multi ? 2'b10 : 2'b01;
        end
        if (m_cnt != 4'd15) m_cnt = m_cnt + 4'd1;
        err_n = 1'b1;
    endtask

    task automatic read_errdata(input string req);
        logic [2:0] keep;
        keep = mode; mode = 3'b000; #0.5;
        check(req, sys_out, m_ed);
        mode = keep; #0.5;
    endtask

    task automatic read_diag(input string req);
        logic [2:0] keep;
        keep = mode;
        mode = 3'b001; #0.5;
        check(req, sys_out, {m_et, 2'b00, m_cnt, m_syn, partial_cb, m_cb});
        mode = 3'b101; #0.5;
        check(req, sys_out, {m_et, 2'b00, m_cnt, m_syn, partial_cb, m_cb});
        mode = keep; #0.5;
    endtask

    task automatic load_cb(input logic [2:0] md, input logic [7:0] mcb, input logic [7:0] scb);
        mode = md; mem_cb = mcb; sys_in = {24'hA5A5A5, scb}; mem_le = 1'b1;
        tick();
        m_cb = (md == 3'b100) ? scb : mcb;
        mem_le = 1'b0;
    endtask

    task automatic t_reset();
        load_cb(3'b011, 8'h3C, 8'h00);
        read_errdata("R8 reset errdata zero");
        partial_cb = 8'h81;
        read_diag("R9 reset diag word");
    endtask

    task automatic t_modes();
        corr_data = 32'hC0DE_1234; mem_data = 32'h0BAD_5678;
        mode = 3'b011; #0.5; check("R1 mode 011", sys_out, corr_data);
        mode = 3'b111; #0.5; check("R1 mode 111", sys_out, corr_data);
        mode = 3'b100; #0.5; check("R1 mode 100", sys_out, corr_data);
        mode = 3'b010; #0.5; check("R2 mode 010", sys_out, mem_data);
        mode = 3'b110; #0.5; check("R2 mode 110", sys_out, mem_data);
        mode = 3'b011;
    endtask

    task automatic t_first_error();
        tick(); tick();
        read_diag("R6 no error edges keep count");
        err_edge(32'h1111_AAAA, 8'h4D, 1'b0);
        read_errdata("R3 R4 first error data");
        err_edge(32'h2222_BBBB, 8'h77, 1'b1);
        read_errdata("R4 second error ignored");
        partial_cb = 8'h5E;
        read_diag("R5 R7 syndrome type count after two");
    endtask

    task automatic t_saturate();
        for (int i = 0; i < 12; i++) err_edge(32'h3000_0000 + i, 8'(i), 1'b1);
        read_diag("R6 count 14");
        err_edge(32'h4444_0000, 8'hEE, 1'b0);
        read_diag("R6 count 15");
        for (int i = 0; i < 5; i++) err_edge(32'h5000_0000 + i, 8'hF0, 1'b0);
        read_diag("R6 saturated at 15");
    endtask

    task automatic t_clear();
        #0.5 clr_n = 1'b0; #0.5;
        model_clear();
        mode = 3'b000; #0.5;
        check("R8 async clear errdata", sys_out, 32'h0);
        mode = 3'b011;
        read_diag("R8 async clear diag");
        // error during clear edge
        mem_data = 32'hDEAD_BEEF; syndrome = 8'h99; err_n = 1'b0;
        tick();
        err_n = 1'b1; clr_n = 1'b1;
        tick();
        read_diag("R11 clear beats capture");
        read_errdata("R11 clear beats capture data");
    endtask

    task automatic t_multi_first();
        err_edge(32'h6666_0001, 8'h13, 1'b1);
        read_diag("R7 multi first type");
        err_edge(32'h6666_0002, 8'h14, 1'b0);
        read_diag("R7 type holds first");
        read_errdata("R4 data after reclear");
    endtask

    task automatic t_inject();
        partial_cb = 8'hA7;
        load_cb(3'b011, 8'h5A, 8'hC3);
        read_diag("R10 normal load from memory");
        load_cb(3'b100, 8'h5A, 8'hC3);
        read_diag("R10 injection load from sys_in");
        mode = 3'b100; mem_cb = 8'h11; sys_in = 32'h0000_0022; mem_le = 1'b0;
        tick(); tick();
        read_diag("R10 latch holds without enable");
        mode = 3'b011;
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        tick(); tick();
        clr_n = 1'b1;
        t_reset();
        t_modes();
        t_first_error();
        t_saturate();
        t_clear();
        t_multi_first();
        t_inject();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule